// File: doc/BRIEF.md
# Flash page program buffer

This block is the data side of a serial flash page-program command. It takes a serial bit stream framed by an active-low chip select, assembles it into bytes and decodes a short command: a write-enable opcode that arms a latch, and a program opcode followed by a 24-bit address and any number of data bytes. The data bytes land in a 256-byte staging buffer with a per-position written mask. The byte pointer starts at the low address byte and wraps inside the page, so a long stream leaves only its final 256 bytes in the buffer.

When chip select rises on a whole-byte boundary after a program command, the block starts a self-timed program cycle. It walks the staging buffer and clears bits in a behavioural memory array, one byte per cycle, for the positions marked in the mask. Busy stays high for a fixed number of cycles, and the write-enable latch drops when busy ends. A registered read port lets the surrounding logic inspect the array.

Back-pressure rule for the bit stream: a bit is taken on a rising clock edge where `si_valid` and `si_ready` are both high. `si_ready` is high only while chip select is low and no program cycle is running. Bits offered while `si_ready` is low are not taken and have no effect.

Top module: `pp_page_prog`

## Requirements
- R1: After reset every array byte reads 0xFF, `wip` and `wel` are 0, and `si_ready` is 0 while `cs_n` is high.
- R2: Opcode 0x06 as the only byte of a select window, with chip select rising right after it, sets `wel`. Opcode 0x02 while `wel` is 0 starts no program cycle and leaves the array unchanged.
- R3: A program command is opcode 0x02 followed by three address bytes, most significant first. Bits within a byte arrive most significant first. Address bits [8 +: log2(NUM_PAGES)] select the page, higher address bits are ignored, and bits [7:0] give the starting byte.
- R4: Programming only clears bits: each written array byte becomes its old value AND the data byte.
- R5: Data that runs past byte 255 of the page continues at byte 0 of the same page.
- R6: When more than 256 data bytes are sent, only the last 256 are programmed. Array positions that received no data byte keep their contents.
- R7: `wip` rises on the clock edge that sees chip select rise after a valid program command, and stays high for exactly PROG_CYCLES cycles. No input bit is taken while `wip` is high.
- R8: `wel` is cleared on the same edge on which `wip` falls.
- R9: If chip select rises while a byte is only partly shifted in (bit count not a multiple of 8), the command is rejected: no program cycle starts, the array is unchanged, and `wel` keeps its value.
- R10: `rd_data` shows the array byte at `rd_addr` one clock cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select framing a command |
| si_valid | input | 1 | Serial bit offered |
| si_bit | input | 1 | Serial bit value |
| si_ready | output | 1 | Block can take a bit this cycle |
| wip | output | 1 | Program cycle running |
| wel | output | 1 | Write-enable latch |
| rd_addr | input | log2(NUM_PAGES)+8 | Array read address {page, byte} |
| rd_data | output | 8 | Array byte, one cycle after `rd_addr` |

## Verification
The hardest state to reach is a staging buffer whose pointer has wrapped more than once, so that some positions hold a second overwrite while others hold their only byte, with each position ending up in the right place of an array page that has already been programmed. The random phase gets there by sending streams of up to 300 bytes from random start offsets. Random upper address bits test that only the page-select bits matter, and repeated commands on the same small array make every AND fold onto earlier contents. Directed cases cover a stray partial byte before chip select rises, a program attempt without the write-enable latch, and an attempt to push bits while busy.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int PAGE_BYTES = 256;
  localparam int IDX_W      = $clog2(PAGE_BYTES);
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_WREN = 8'h06;

  typedef enum logic [2:0] {
    ST_OPC, ST_A2, ST_A1, ST_A0, ST_DATA, ST_WREN, ST_SKIP
  } cmd_st_t;
endpackage

// File: rtl/pp_shift.sv
module pp_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       take,
  input  logic       bit_in,
  output logic       byte_stb,
  output logic [7:0] byte_out,
  output logic       partial
);
  logic [6:0] sr;
  logic [2:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (cs_n) begin
      cnt <= '0;
    end else if (take) begin
      sr  <= {sr[5:0], bit_in};
      cnt <= cnt + 3'd1;
    end
  end

  assign byte_stb = take && (cnt == 3'd7);
  assign byte_out = {sr, bit_in};
  assign partial  = (cnt != 3'd0);

  // R9
  shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !partial);
endmodule

// File: rtl/pp_cmd.sv
module pp_cmd import pp_pkg::*; #(
  parameter int PG_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            byte_stb,
  input  logic [7:0]      byte_in,
  input  logic            partial,
  input  logic            wip,
  input  logic            prog_done,
  output logic            wel,
  output logic            commit,
  output logic [PG_W-1:0] page_out,
  output logic            load,
  output logic [IDX_W-1:0] load_idx,
  output logic            wr
);
  cmd_st_t st;
  logic    cs_q;
  logic    cs_rise;

  assign cs_rise  = cs_n && !cs_q;
  assign commit   = cs_rise && !partial && (st == ST_DATA) && !wip;
  assign load     = byte_stb && (st == ST_A0);
  assign load_idx = byte_in;
  assign wr       = byte_stb && (st == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OPC;
      cs_q     <= 1'b1;
      wel      <= 1'b0;
      page_out <= '0;
    end else begin
      cs_q <= cs_n;
      if (prog_done) wel <= 1'b0;
      if (cs_n) begin
        st <= ST_OPC;
        if (cs_rise && !partial && st == ST_WREN) wel <= 1'b1;
      end else if (byte_stb) begin
        case (st)
          ST_OPC: begin
            if (byte_in == OPC_PROG && wel) st <= ST_A2;
            else if (byte_in == OPC_WREN)   st <= ST_WREN;
            else                            st <= ST_SKIP;
          end
          ST_A2: begin
            page_out <= PG_W'({page_out, byte_in});
            st       <= ST_A1;
          end
          ST_A1: begin
            page_out <= PG_W'({page_out, byte_in});
            st       <= ST_A0;
          end
          ST_A0:   st <= ST_DATA;
          ST_DATA: st <= ST_DATA;
          default: st <= ST_SKIP;
        endcase
      end
    end
  end

  // R2
  commit_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> wel);
  // R8
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !wel);
endmodule

// File: rtl/pp_pagebuf.sv
module pp_pagebuf import pp_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             wr,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic             rd_valid
);
  logic [7:0]            data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [IDX_W-1:0]      ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      ptr  <= '0;
    end else if (load) begin
      mask <= '0;
      ptr  <= load_idx;
    end else if (wr) begin
      mask[ptr] <= 1'b1;
      ptr       <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !load) data[ptr] <= wr_data;
  end

  assign rd_byte  = data[rd_idx];
  assign rd_valid = mask[rd_idx];

  // R7
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(wr || load));
endmodule

// File: rtl/pp_array.sv
module pp_array import pp_pkg::*; #(
  parameter int NUM_PAGES   = 4,
  parameter int PROG_CYCLES = 300
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  commit,
  input  logic [$clog2(NUM_PAGES)-1:0]          page_in,
  input  logic [7:0]                            buf_byte,
  input  logic                                  buf_valid,
  input  logic [$clog2(NUM_PAGES)+IDX_W-1:0]    rd_addr,
  output logic [IDX_W-1:0]                      buf_idx,
  output logic                                  wip,
  output logic                                  prog_done,
  output logic [7:0]                            rd_data
);
  // PROG_CYCLES must be at least PAGE_BYTES so that every buffer slot is visited.
  localparam int PG_W   = $clog2(NUM_PAGES);
  localparam int MEM_N  = NUM_PAGES * PAGE_BYTES;
  localparam int TMR_W  = $clog2(PROG_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(PROG_CYCLES - 1);
  localparam logic [TMR_W-1:0] TMR_PAGE = TMR_W'(PAGE_BYTES);

  logic [7:0]       arr [MEM_N];
  logic [TMR_W-1:0] tmr;
  logic [PG_W-1:0]  pg;
  logic             we;

  assign prog_done = wip && (tmr == TMR_LAST);
  assign buf_idx   = tmr[IDX_W-1:0];
  assign we        = wip && (tmr < TMR_PAGE) && buf_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip <= 1'b0;
      tmr <= '0;
      pg  <= '0;
    end else if (commit) begin
      wip <= 1'b1;
      tmr <= '0;
      pg  <= page_in;
    end else if (wip) begin
      if (prog_done) wip <= 1'b0;
      tmr <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_N; i++) arr[i] <= 8'hFF;
      rd_data <= 8'hFF;
    end else begin
      if (we) arr[{pg, buf_idx}] <= arr[{pg, buf_idx}] & buf_byte;
      rd_data <= arr[rd_addr];
    end
  end

  // R7
  wip_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !wip);
  // R7
  wip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && !prog_done) |=> wip);
endmodule

// File: rtl/pp_page_prog.sv
module pp_page_prog import pp_pkg::*; #(
  parameter int NUM_PAGES   = 4,
  parameter int PROG_CYCLES = 300
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cs_n,
  input  logic                                si_valid,
  input  logic                                si_bit,
  output logic                                si_ready,
  output logic                                wip,
  output logic                                wel,
  input  logic [$clog2(NUM_PAGES)+IDX_W-1:0]  rd_addr,
  output logic [7:0]                          rd_data
);
  localparam int PG_W = $clog2(NUM_PAGES);

  logic             take, byte_stb, partial, commit, load, wr, prog_done, buf_valid;
  logic [7:0]       byte_val, buf_byte;
  logic [IDX_W-1:0] load_idx, buf_idx;
  logic [PG_W-1:0]  page_sel;

  assign si_ready = !cs_n && !wip;
  assign take     = si_valid && si_ready;

  pp_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .take(take), .bit_in(si_bit),
    .byte_stb(byte_stb), .byte_out(byte_val), .partial(partial)
  );

  pp_cmd #(.PG_W(PG_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_stb(byte_stb),
    .byte_in(byte_val), .partial(partial), .wip(wip), .prog_done(prog_done),
    .wel(wel), .commit(commit), .page_out(page_sel), .load(load),
    .load_idx(load_idx), .wr(wr)
  );

  pp_pagebuf u_buf (
    .clk(clk), .rst_n(rst_n), .busy(wip), .load(load), .load_idx(load_idx),
    .wr(wr), .wr_data(byte_val), .rd_idx(buf_idx), .rd_byte(buf_byte),
    .rd_valid(buf_valid)
  );

  pp_array #(.NUM_PAGES(NUM_PAGES), .PROG_CYCLES(PROG_CYCLES)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit), .page_in(page_sel),
    .buf_byte(buf_byte), .buf_valid(buf_valid), .rd_addr(rd_addr),
    .buf_idx(buf_idx), .wip(wip), .prog_done(prog_done), .rd_data(rd_data)
  );

  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !si_ready);
  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !si_ready);
endmodule

// File: tb/test_pp_page_prog.sv
module test_pp_page_prog;
  localparam int CLK_PERIOD  = 10;
  localparam int NUM_PAGES   = 4;
  localparam int PROG_CYCLES = 300;
  localparam int AW          = $clog2(NUM_PAGES) + 8;
  localparam int MEM_N       = NUM_PAGES * 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic si_valid = 1'b0;
  logic si_bit = 1'b0;
  logic si_ready, wip, wel;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_mem [MEM_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_page_prog #(.NUM_PAGES(NUM_PAGES), .PROG_CYCLES(PROG_CYCLES)) i_pp_page_prog (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .si_valid(si_valid), .si_bit(si_bit),
    .si_ready(si_ready), .wip(wip), .wel(wel), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int page_of(input logic [23:0] a);
    return int'(a[8 +: $clog2(NUM_PAGES)]);
  endfunction

  function automatic logic [7:0] prog_byte(input logic [7:0] old_v, input logic [7:0] d);
    return old_v & d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    si_valid = 1'b1;
    si_bit   = b;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic end_frame();
    si_valid = 1'b0;
    cs_n     = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_mem(input string req);
    int bad = 0;
    logic [7:0] first_act = 0, first_exp = 0;
    for (int a = 0; a < MEM_N; a++) begin
      rd_addr = AW'(a);
      @(negedge clk);
      if (rd_data !== exp_mem[a]) begin
        if (bad == 0) begin first_act = rd_data; first_exp = exp_mem[a]; end
        bad++;
      end
    end
    check(req, {24'd0, first_act}, {24'd0, first_exp});
  endtask

  task automatic wren();
    cs_n = 1'b0;
    @(negedge clk);
    send_byte(8'h06);
    end_frame();
    @(negedge clk);
    check("R2 wel after write-enable", {31'd0, wel}, 32'd1);
  endtask

  task automatic prog(input logic [23:0] addr, input int n, input int extra_bits,
                      input bit expect_commit, input bit poke_busy);
    logic [7:0] bm [256];
    bit mk [256];
    logic [7:0] ptr;
    logic wel_before;
    int cnt;
    for (int i = 0; i < 256; i++) begin bm[i] = 8'h00; mk[i] = 1'b0; end
    wel_before = wel;
    cs_n = 1'b0;
    @(negedge clk);
    send_byte(8'h02);
    send_byte(addr[23:16]);
    send_byte(addr[15:8]);
    send_byte(addr[7:0]);
    ptr = addr[7:0];
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      send_byte(d);
      bm[ptr] = d;
      mk[ptr] = 1'b1;
      ptr = ptr + 8'd1;
    end
    for (int i = 0; i < extra_bits; i++) send_bit(1'($urandom));
    end_frame();
    check("R7 wip after chip select rise", {31'd0, wip}, {31'd0, expect_commit});
    if (expect_commit) begin
      cnt = 0;
      while (wip && cnt < 4 * PROG_CYCLES) begin
        cnt++;
        if (poke_busy && cnt == 5) begin
          cs_n = 1'b0;
          si_valid = 1'b1;
          si_bit = 1'b0;
        end
        if (poke_busy && cnt == 6)
          check("R7 ready low while busy", {31'd0, si_ready}, 32'd0);
        if (poke_busy && cnt == 20) begin
          si_valid = 1'b0;
          cs_n = 1'b1;
        end
        @(negedge clk);
      end
      check("R7 busy length", cnt, PROG_CYCLES);
      check("R8 wel cleared after program", {31'd0, wel}, 32'd0);
      for (int i = 0; i < 256; i++)
        if (mk[i]) begin
          int idx = page_of(addr) * 256 + i;
          exp_mem[idx] = prog_byte(exp_mem[idx], bm[i]);
        end
    end else begin
      repeat (3) @(negedge clk);
      check("R9 no busy on rejected command", {31'd0, wip}, 32'd0);
      check("R9 wel kept on rejected command", {31'd0, wel}, {31'd0, wel_before});
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < MEM_N; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wip at reset", {31'd0, wip}, 32'd0);
    check("R1 wel at reset", {31'd0, wel}, 32'd0);
    check("R1 ready with chip select high", {31'd0, si_ready}, 32'd0);
    check_mem("R1 erased array R10");

    // R2: program without the latch does nothing
    prog(24'h000120, 10, 0, 1'b0, 1'b0);
    check("R2 wel still clear", {31'd0, wel}, 32'd0);
    check_mem("R2 array untouched");

    // R3 R4: plain program then a second program on the same page
    wren();
    prog(24'h000110, 20, 0, 1'b1, 1'b1);
    check_mem("R3 program at start byte");
    wren();
    prog(24'hFF0118, 20, 0, 1'b1, 1'b0);
    check_mem("R4 bits only cleared");

    // R5: wrap within page
    wren();
    prog(24'h0002F0, 40, 0, 1'b1, 1'b0);
    check_mem("R5 wrap inside page");

    // R6: more than 256 bytes
    wren();
    prog(24'h000340, 300, 0, 1'b1, 1'b0);
    check_mem("R6 last 256 bytes kept");

    // R9: partial final byte rejects, latch kept, then valid program
    wren();
    prog(24'h000008, 12, 3, 1'b0, 1'b0);
    check_mem("R9 array unchanged on partial byte");
    prog(24'h000008, 12, 0, 1'b1, 1'b0);
    check_mem("R9 program after rejection");

    // random mix
    for (int k = 0; k < 6; k++) begin
      logic [23:0] a;
      a = 24'($urandom);
      wren();
      prog(a, 1 + int'($urandom % 300), 0, 1'b1, 1'b0);
      check_mem("R6 random stream");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule